// File: doc/BRIEF.md
# Receive Address Filter and Frame Buffer

This block sits behind the bit decoder of a vehicle network receiver. It takes a stream of decoded bytes with start-of-frame and end-of-frame markers. It runs a CRC-8 check over each frame and decides from the addressing byte whether the frame is meant for this node. Frames that are good and addressed to this node are written into a store that holds two frames. The host then drains the store byte by byte through a valid/ready read port.

A frame is a header byte, then a target address byte, then zero or more payload bytes, then one CRC byte. Bit 2 of the header selects the addressing kind: 1 means physical and 0 means functional. Acceptance is decided in three ways. A physical frame is accepted when its target equals the configured node address. A functional frame is accepted when its target equals any enabled entry of a fifteen-entry functional table. Any frame whose target is 0xFF is accepted as broadcast. Each frame that fails is reported through a one-cycle flag: a CRC error, a length error, or an overrun.

The input side never applies back-pressure: `in_ready` is tied high, because the bus cannot be stalled. On the output side, `out_data` and `out_last` must hold steady while `out_valid` is high and `out_ready` is low. A byte moves on every cycle where both are high.

Top module: `rx_filter_buf`

## Requirements
- R1: After reset, `out_valid`, `frames_ready`, `crc_err`, `len_err` and `overrun` are all 0.
- R2: The host reads back an accepted frame in arrival byte order, from header to CRC byte. `out_last` is high on the CRC byte only.
- R3: The CRC is CRC-8 with polynomial 0x1D, initial value 0xFF, MSB first, and a final inversion. It covers every byte except the last. When the last byte differs from this CRC, the frame is discarded and `crc_err` pulses for one cycle.
- R4: With header bit 2 = 1, a good frame whose target equals `phys_addr` is stored.
- R5: With header bit 2 = 0, a good frame is stored when its target equals functional entry i (`func_addr[8*i+7:8*i]`) and `func_en[i]` is 1. A disabled entry does not match.
- R6: A good frame with target 0xFF is stored in both addressing kinds.
- R7: A good frame that matches no address is dropped with no flag raised.
- R8: Up to two frames are held at once. `frames_ready` gives their count, and the host receives them oldest first.
- R9: An accepted frame that starts while both slots are full is dropped, and `overrun` pulses. The two stored frames stay intact.
- R10: A frame shorter than 3 bytes or longer than FRAME_MAX bytes is discarded, and `len_err` pulses. A frame of exactly FRAME_MAX bytes is valid.
- R11: While `out_valid` is high and `out_ready` is low, `out_data` and `out_last` hold. After the last byte is taken, the slot is released.
- R12: `frames_ready`, `out_valid` and the flags change on the clock edge that takes the end-of-frame byte, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Decoded byte present |
| in_ready | output | 1 | Always 1; the input side never stalls |
| in_sof | input | 1 | Byte is the first of a frame |
| in_eof | input | 1 | Byte is the last of a frame |
| in_data | input | 8 | Decoded byte |
| phys_addr | input | 8 | Node physical address |
| func_addr | input | 120 | Fifteen functional addresses, entry i at bits 8i+7:8i |
| func_en | input | 15 | Enable per functional entry |
| out_valid | output | 1 | Host byte available |
| out_ready | input | 1 | Host takes the byte |
| out_data | output | 8 | Host byte |
| out_last | output | 1 | Byte is the last of its frame |
| frames_ready | output | 2 | Number of stored frames (0 to 2) |
| crc_err | output | 1 | One-cycle pulse: CRC mismatch |
| len_err | output | 1 | One-cycle pulse: bad frame length |
| overrun | output | 1 | One-cycle pulse: accepted frame dropped for lack of space |

## Verification
The assertions assume three things about the inputs. Bytes of a frame arrive only between a start marker and an end marker. `out_ready` may change freely. The address configuration holds steady while a frame is in flight. The stimulus always opens a frame with `in_sof` and leaves idle gaps only between bytes. It sets the address table once, before traffic starts. It drains the store only between frames, so the slot decision taken at the start of a frame matches the model's count. Random frames mix all target kinds, corrupted CRCs and out-of-range lengths, and the host stalls at random.

// File: rtl/rxaf_pkg.sv
package rxaf_pkg;
  localparam int BYTE_W = 8;
  localparam logic [7:0] CRC_POLY = 8'h1D;
  localparam logic [7:0] CRC_SEED = 8'hFF;
  localparam logic [7:0] BCAST_ADDR = 8'hFF;
  localparam int HDR_KIND_BIT = 2;

  // one byte of CRC-8, MSB first
  function automatic logic [7:0] crc8_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    logic fb;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      fb = r[7] ^ d[i];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction
endpackage

// File: rtl/rxaf_addr_match.sv
module rxaf_addr_match #(
  parameter int N_FUNC = 15
) (
  input  logic [7:0]          tgt,
  input  logic                phys_kind,
  input  logic [7:0]          phys_addr,
  input  logic [N_FUNC*8-1:0] func_addr,
  input  logic [N_FUNC-1:0]   func_en,
  output logic                hit
);
  import rxaf_pkg::*;
  logic [N_FUNC-1:0] fhit;

  for (genvar i = 0; i < N_FUNC; i++) begin : g_func
    assign fhit[i] = func_en[i] && (func_addr[i*8 +: 8] == tgt);
  end

  always_comb begin
    if (tgt == BCAST_ADDR) hit = 1'b1;
    else if (phys_kind)    hit = (tgt == phys_addr);
    else                   hit = |fhit;
  end
endmodule

// File: rtl/rxaf_frame_rx.sv
module rxaf_frame_rx #(
  parameter int FRAME_MAX = 12,
  localparam int IW = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  input  logic          in_eof,
  input  logic [7:0]    in_data,
  input  logic          slot_free,
  input  logic          addr_hit,
  output logic          phys_kind,
  output logic          wr_en,
  output logic [IW-1:0] wr_idx,
  output logic          commit,
  output logic [IW-1:0] commit_len,
  output logic          crc_err,
  output logic          len_err,
  output logic          overrun
);
  import rxaf_pkg::*;

  logic          active, slot_ok, accept, too_long;
  logic [IW-1:0] idx;
  logic [7:0]    crc;
  logic          end_now, len_good, crc_good;

  assign end_now  = in_valid && !in_sof && active && in_eof;
  assign len_good = !too_long && (idx < IW'(FRAME_MAX)) && (idx >= IW'(2));
  assign crc_good = ((crc ^ 8'hFF) == in_data);
  assign commit   = end_now && len_good && crc_good && accept && slot_ok;
  assign commit_len = idx + 1'b1;

  always_comb begin
    wr_en  = 1'b0;
    wr_idx = idx;
    if (in_valid && in_sof) begin
      wr_en  = slot_free;
      wr_idx = '0;
    end else if (in_valid && active) begin
      wr_en = slot_ok && (idx < IW'(FRAME_MAX));
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0; slot_ok <= 1'b0; accept <= 1'b0; too_long <= 1'b0;
      idx <= '0; crc <= CRC_SEED; phys_kind <= 1'b0;
      crc_err <= 1'b0; len_err <= 1'b0; overrun <= 1'b0;
    end else begin
      crc_err <= 1'b0; len_err <= 1'b0; overrun <= 1'b0;
      if (in_valid && in_sof) begin
        active    <= !in_eof;
        idx       <= IW'(1);
        crc       <= crc8_step(CRC_SEED, in_data);
        phys_kind <= in_data[HDR_KIND_BIT];
        accept    <= 1'b0;
        too_long  <= 1'b0;
        slot_ok   <= slot_free;
        if (in_eof) len_err <= 1'b1;
      end else if (in_valid && active) begin
        if (idx == IW'(1)) accept <= addr_hit;
        crc <= crc8_step(crc, in_data);
        if (idx < IW'(FRAME_MAX)) idx <= idx + 1'b1;
        else too_long <= 1'b1;
        if (in_eof) begin
          active <= 1'b0;
          if (!len_good)     len_err <= 1'b1;
          else if (!crc_good) crc_err <= 1'b1;
          else if (accept && !slot_ok) overrun <= 1'b1;
        end
      end
    end
  end

  // R3
  one_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({crc_err, len_err, overrun}));
  // R2
  commit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !crc_err && !len_err && !overrun);
  // R10
  commit_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> (commit_len >= IW'(3)) && (commit_len <= IW'(FRAME_MAX)));
endmodule

// File: rtl/rxaf_slot_store.sv
module rxaf_slot_store #(
  parameter int FRAME_MAX = 12,
  localparam int IW = $clog2(FRAME_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [7:0]    wr_data,
  input  logic          commit,
  input  logic [IW-1:0] commit_len,
  output logic          slot_free,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          out_last,
  output logic [1:0]    frames_ready
);
  logic [7:0]    mem [2][FRAME_MAX];
  logic [IW-1:0] len [2];
  logic [1:0]    full;
  logic          wr_slot, rd_slot;
  logic [IW-1:0] rd_idx;
  logic          pop, pop_last;

  assign slot_free    = !full[wr_slot];
  assign out_valid    = full[rd_slot];
  assign out_data     = mem[rd_slot][rd_idx];
  assign out_last     = (rd_idx == len[rd_slot] - 1'b1);
  assign pop          = out_valid && out_ready;
  assign pop_last     = pop && out_last;
  assign frames_ready = {1'b0, full[0]} + {1'b0, full[1]};

  for (genvar s = 0; s < 2; s++) begin : g_slot
    always_ff @(posedge clk) begin
      if (wr_en && (wr_slot == 1'(s))) mem[s][wr_idx] <= wr_data;
    end
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        full[s] <= 1'b0;
        len[s]  <= '0;
      end else if (commit && (wr_slot == 1'(s))) begin
        full[s] <= 1'b1;
        len[s]  <= commit_len;
      end else if (pop_last && (rd_slot == 1'(s))) begin
        full[s] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_slot <= 1'b0; rd_slot <= 1'b0; rd_idx <= '0;
    end else begin
      if (commit) wr_slot <= !wr_slot;
      if (pop_last) begin
        rd_slot <= !rd_slot;
        rd_idx  <= '0;
      end else if (pop) begin
        rd_idx <= rd_idx + 1'b1;
      end
    end
  end

  // R11
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));
  // R9
  no_overwrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> !full[wr_slot]);
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frames_ready <= 2'd2);
  // R8
  valid_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> frames_ready != 2'd0);
endmodule

// File: rtl/rx_filter_buf.sv
module rx_filter_buf #(
  parameter int FRAME_MAX = 12,
  parameter int N_FUNC = 15,
  localparam int IW = $clog2(FRAME_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic                in_sof,
  input  logic                in_eof,
  input  logic [7:0]          in_data,
  input  logic [7:0]          phys_addr,
  input  logic [N_FUNC*8-1:0] func_addr,
  input  logic [N_FUNC-1:0]   func_en,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [7:0]          out_data,
  output logic                out_last,
  output logic [1:0]          frames_ready,
  output logic                crc_err,
  output logic                len_err,
  output logic                overrun
);
  logic          phys_kind, addr_hit, slot_free, wr_en, commit;
  logic [IW-1:0] wr_idx, commit_len;

  assign in_ready = 1'b1;

  rxaf_addr_match #(.N_FUNC(N_FUNC)) u_match (
    .tgt(in_data), .phys_kind(phys_kind), .phys_addr(phys_addr),
    .func_addr(func_addr), .func_en(func_en), .hit(addr_hit)
  );

  rxaf_frame_rx #(.FRAME_MAX(FRAME_MAX)) u_rx (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_eof(in_eof), .in_data(in_data), .slot_free(slot_free),
    .addr_hit(addr_hit), .phys_kind(phys_kind), .wr_en(wr_en),
    .wr_idx(wr_idx), .commit(commit), .commit_len(commit_len),
    .crc_err(crc_err), .len_err(len_err), .overrun(overrun)
  );

  rxaf_slot_store #(.FRAME_MAX(FRAME_MAX)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(in_data), .commit(commit), .commit_len(commit_len),
    .slot_free(slot_free), .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_last(out_last), .frames_ready(frames_ready)
  );

  // R12
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit && !(out_valid && out_ready && out_last) |=> $stable(frames_ready));
endmodule

// File: tb/rx_filter_buf_test.sv
module rx_filter_buf_test;
  localparam int MAXL = 12;
  localparam int NF = 15;
  localparam int OC_NONE = 0, OC_COMMIT = 1, OC_CRC = 2, OC_LEN = 3, OC_OVR = 4;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_sof = 0, in_eof = 0, out_ready = 0;
  logic [7:0] in_data = 0, phys_addr;
  logic [NF*8-1:0] func_addr;
  logic [NF-1:0] func_en;
  logic in_ready, out_valid, out_last, crc_err, len_err, overrun;
  logic [7:0] out_data;
  logic [1:0] frames_ready;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [7:0] fb [0:15];
  logic [7:0] qm [0:1][0:15];
  int ql [0:1];
  int qh = 0, qc = 0;

  always #5 clk = ~clk;

  rx_filter_buf uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_eof(in_eof), .in_data(in_data), .phys_addr(phys_addr),
    .func_addr(func_addr), .func_en(func_en), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .frames_ready(frames_ready), .crc_err(crc_err), .len_err(len_err),
    .overrun(overrun)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_crc(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c = c ^ fb[i];
      for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return ~c;
  endfunction

  function automatic bit ref_hit(input logic [7:0] hdr, input logic [7:0] t);
    if (t == 8'hFF) return 1;
    if (hdr[2]) return t == phys_addr;
    for (int i = 0; i < NF; i++) if (func_en[i] && func_addr[i*8 +: 8] == t) return 1;
    return 0;
  endfunction

  function automatic int ref_outcome(input int n);
    if (n < 3 || n > MAXL) return OC_LEN;
    if (ref_crc(n - 1) != fb[n-1]) return OC_CRC;
    if (!ref_hit(fb[0], fb[1])) return OC_NONE;
    if (qc == 2) return OC_OVR;
    return OC_COMMIT;
  endfunction

  task automatic make_frame(input int n, input bit phys, input logic [7:0] t, input bit bad);
    for (int i = 0; i < 16; i++) fb[i] = 8'($urandom);
    fb[0][2] = phys;
    fb[1] = t;
    if (n >= 2) fb[n-1] = ref_crc(n - 1) ^ (bad ? 8'h01 : 8'h00);
  endtask

  task automatic send(input int n, input string req);
    int oc;
    oc = ref_outcome(n);
    for (int i = 0; i < n; i++) begin
      if (i > 0 && $urandom % 4 == 0) begin
        @(posedge clk); #1 in_valid = 0;
      end
      @(posedge clk); #1;
      in_valid = 1; in_sof = (i == 0); in_eof = (i == n - 1); in_data = fb[i];
    end
    @(negedge clk);
    chk(frames_ready == 2'(qc), "R12 count before end edge", frames_ready, qc);
    @(posedge clk); #1;
    in_valid = 0; in_sof = 0; in_eof = 0;
    if (oc == OC_COMMIT) begin
      for (int i = 0; i < n; i++) qm[(qh + qc) % 2][i] = fb[i];
      ql[(qh + qc) % 2] = n;
      qc++;
    end
    chk(crc_err == (oc == OC_CRC), {req, " R3 crc_err"}, crc_err, oc == OC_CRC);
    chk(len_err == (oc == OC_LEN), {req, " R10 len_err"}, len_err, oc == OC_LEN);
    chk(overrun == (oc == OC_OVR), {req, " R9 overrun"}, overrun, oc == OC_OVR);
    chk(frames_ready == 2'(qc), {req, " R8 count"}, frames_ready, qc);
  endtask

  task automatic read_one(input string req);
    int beat = 0, guard = 0;
    chk(out_valid == 1'b1, {req, " R8 valid"}, out_valid, 1);
    while (beat < ql[qh] && guard < 200) begin
      guard++;
      @(posedge clk); #1 out_ready = ($urandom % 10) < 7;
      @(negedge clk);
      if (out_ready && out_valid) begin
        chk(out_data == qm[qh][beat], {req, " R2 data"}, out_data, qm[qh][beat]);
        chk(out_last == (beat == ql[qh] - 1), {req, " R2 last"}, out_last, beat == ql[qh] - 1);
        beat++;
      end
    end
    @(posedge clk); #1 out_ready = 0;
    qh = (qh + 1) % 2; qc--;
    chk(frames_ready == 2'(qc), {req, " R11 release"}, frames_ready, qc);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    phys_addr = 8'hA5;
    for (int i = 0; i < NF; i++) func_addr[i*8 +: 8] = 8'(8'h10 + i * 3);
    func_en = 15'h7BFF;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk(out_valid == 0 && frames_ready == 0, "R1 outputs", {out_valid, frames_ready}, 0);
    chk(!crc_err && !len_err && !overrun, "R1 flags", {crc_err, len_err, overrun}, 0);

    make_frame(5, 1, 8'hA5, 0);  send(5, "R4 phys");  read_one("R4 R11");
    make_frame(4, 0, 8'h13, 0);  send(4, "R5 func");  read_one("R5");
    make_frame(4, 0, 8'h2E, 0);  send(4, "R5 disabled entry");
    make_frame(4, 0, 8'hA5, 0);  send(4, "R7 phys addr in func kind");
    make_frame(3, 0, 8'hFF, 0);  send(3, "R6 bcast func");
    make_frame(MAXL, 1, 8'hFF, 0); send(MAXL, "R6 R10 bcast phys max length");
    make_frame(6, 1, 8'hA5, 0);  send(6, "R9 full");
    read_one("R8 order first"); read_one("R8 order second");
    make_frame(5, 1, 8'hA5, 1);  send(5, "R3 bad crc");
    make_frame(2, 1, 8'hFF, 0);  send(2, "R10 short");
    make_frame(1, 1, 8'hFF, 0);  send(1, "R10 single");
    make_frame(MAXL + 1, 1, 8'hFF, 0); send(MAXL + 1, "R10 long");

    for (int it = 0; it < 80; it++) begin
      int n, pick;
      bit phys;
      logic [7:0] t;
      phys = 1'($urandom);
      pick = $urandom % 5;
      case (pick)
        0: begin t = phys_addr; phys = 1; end
        1: begin t = func_addr[($urandom % NF) * 8 +: 8]; phys = 0; end
        2: t = 8'hFF;
        3: t = 8'($urandom);
        default: begin t = phys_addr; phys = 0; end
      endcase
      n = ($urandom % 10 == 0) ? ((($urandom % 2) == 0) ? 1 + $urandom % 2 : MAXL + 1 + $urandom % 2)
                               : 3 + $urandom % (MAXL - 2);
      make_frame(n, phys, t, ($urandom % 6) == 0);
      send(n, "random");
      if (qc > 0 && (qc == 2 || $urandom % 3 == 0)) read_one("R8 random drain");
    end
    while (qc > 0) read_one("R8 final drain");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule